// File: doc/BRIEF.md
# Clock Activity Detector with Self-Test

This block watches a monitored clock from an independent reference clock domain. When it sees no edge of the monitored clock for a set number of reference cycles, it raises a loss-of-timing error. The error stays raised until someone clears it by hand. A clear takes effect only if the monitored clock is running again; if the clock is still absent, the error simply stays up. The block takes the monitored clock through a synchroniser chain and finds its toggles by comparing successive synchronised samples. An idle counter measures how long it has been since the last toggle.

A self-test level forces the error on for as long as it is held. When the level is released, the block makes a one-cycle clear of its own. With a live monitored clock this returns the detector to the no-error state. With an absent clock the error remains.

The state machine has three states:

- `CM_HEALTHY`: no error.
- `CM_LOST`: error latched.
- `CM_TEST`: error forced by self-test.

Its transitions are:

- **T_ENTER_TEST**: from any state to `CM_TEST` whenever `self_test` is 1.
- **T_LOSE**: from `CM_HEALTHY` to `CM_LOST` when the idle counter reaches its limit.
- **T_CLEAR**: from `CM_LOST` to `CM_HEALTHY` on `clr_req` while the counter is below its limit.
- **T_RELEASE_OK**: from `CM_TEST` to `CM_HEALTHY` on the self-test falling edge while the clock is active.
- **T_RELEASE_LOST**: from `CM_TEST` to `CM_LOST` on the self-test falling edge while the clock is absent.

In every other case the state holds. The output `timing_err` is registered from the next state and is 1 in every state except `CM_HEALTHY`.

Top module: `clkmon_top`

## Requirements
- R1: After reset, `timing_err` is 0.
- R2: `timing_err` stays 0 while the monitored clock toggles at least once every `IDLE_LIMIT` reference cycles.
- R3: If the monitored clock stops, `timing_err` rises within `IDLE_LIMIT`+4 reference cycles of its last edge.
- R4: Once set, `timing_err` stays 1 when the monitored clock resumes, until a clear occurs.
- R5: A one-cycle `clr_req` pulse while the monitored clock is active drives `timing_err` to 0 one reference cycle later.
- R6: A `clr_req` pulse while the monitored clock is still absent leaves `timing_err` at 1.
- R7: A `clr_req` pulse in the no-error state leaves `timing_err` at 0.
- R8: While `self_test` is 1, `timing_err` is 1 from the following reference cycle on, whatever the monitored clock does.
- R9: On the 1-to-0 transition of `self_test`, an internal one-cycle clear is applied. `timing_err` becomes 0 one cycle later if the clock is active, and stays 1 if it is absent.
- R10: `self_test` takes priority over `clr_req`: a clear pulse while self-test is held leaves `timing_err` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mon_clk | input | 1 | Monitored clock, asynchronous to `ref_clk` |
| clr_req | input | 1 | Manual clear pulse, synchronous to `ref_clk` |
| self_test | input | 1 | Self-test level, synchronous to `ref_clk` |
| timing_err | output | 1 | Loss-of-timing error flag |

## Verification
The assertions check four one-cycle consequences on every cycle:

- A held self-test forces the error.
- A saturated idle counter forces the error unless self-test is active.
- A clear with an active clock removes the error.
- A latched error or a healthy state persists when neither a clear nor a self-test release happens.

Only the bench's scenarios can show the end-to-end behaviour. That covers the detection latency measured from the monitored pin, resumption after a loss, and the different outcome of a self-test release with the clock running and with it stopped. For these the bench compares the flag against its reference model on every cycle.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        CM_HEALTHY = 2'd0,
        CM_LOST    = 2'd1,
        CM_TEST    = 2'd2
    } cm_state_e;

endpackage

// File: rtl/clkmon_sync.sv
// Synchroniser chain for the monitored clock plus toggle detection.
module clkmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic toggle_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= async_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign toggle_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/clkmon_timer.sv
// Counts reference cycles since the last monitored toggle; saturates at LIMIT.
module clkmon_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic stale_o
);
    localparam int             CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LIM = CW'(LIMIT);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             idle_q <= '0;
        else if (toggle_i)      idle_q <= '0;
        else if (idle_q != LIM) idle_q <= idle_q + 1'b1;
    end

    assign stale_o = (idle_q == LIM);

endmodule

// File: rtl/clkmon_fsm.sv
// Error state machine: latch, manual clear, self-test force and auto clear.
module clkmon_fsm
    import clkmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stale_i,
    input  logic clr_req,
    input  logic self_test,
    output logic err_o
);
    cm_state_e state_q, state_d;
    logic      test_q;
    logic      auto_clr;

    // one-cycle automatic clear on the self-test falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) test_q <= 1'b0;
        else        test_q <= self_test;
    end
    assign auto_clr = test_q & ~self_test;

    // next state
    always_comb begin
        state_d = state_q;
        if (self_test) begin
            state_d = CM_TEST;                       // T_ENTER_TEST
        end else begin
            unique case (state_q)
                CM_HEALTHY: if (stale_i) state_d = CM_LOST;          // T_LOSE
                CM_LOST:    if (clr_req && !stale_i) state_d = CM_HEALTHY; // T_CLEAR
                CM_TEST: begin
                    if (auto_clr && !stale_i) state_d = CM_HEALTHY;  // T_RELEASE_OK
                    else                      state_d = CM_LOST;     // T_RELEASE_LOST
                end
                default:    state_d = CM_LOST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_HEALTHY;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= (state_d != CM_HEALTHY);
    end

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_LIMIT  = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic clr_req,
    input  logic self_test,
    output logic timing_err
);
    logic toggle_w;
    logic stale_w;

    clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in (mon_clk),
        .toggle_o (toggle_w)
    );

    clkmon_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .toggle_i (toggle_w),
        .stale_o  (stale_w)
    );

    clkmon_fsm u_fsm (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .stale_i   (stale_w),
        .clr_req   (clr_req),
        .self_test (self_test),
        .err_o     (timing_err)
    );

endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk (
    input logic ref_clk,
    input logic rst_n,
    input logic clr_req,
    input logic self_test,
    input logic stale,
    input logic timing_err
);
    logic prev_test;
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) prev_test <= 1'b0;
        else        prev_test <= self_test;
    end

    // R8
    test_forces_err_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        self_test |=> timing_err);

    // R3
    stale_sets_err_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stale && !self_test |=> timing_err);

    // R5
    clear_active_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        timing_err && clr_req && !stale && !self_test |=> !timing_err);

    // R4
    err_latched_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        timing_err && !clr_req && !self_test && !prev_test |=> timing_err);

    // R2
    healthy_holds_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !timing_err && !stale && !self_test |=> !timing_err);

endmodule

bind clkmon_top clkmon_chk chk_i (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .clr_req    (clr_req),
    .self_test  (self_test),
    .stale      (stale_w),
    .timing_err (timing_err)
);

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
    localparam int LIMIT = 16;

    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic clr_req = 1'b0;
    logic self_test = 1'b0;
    logic timing_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    // monitored clock control
    bit mon_run = 1'b0;
    int mon_half = 3;
    int mon_cnt = 0;

    // reference model state
    bit sq[$];
    bit m_s1, m_prev, m_stprev;
    int m_idle;
    int m_state;   // 0 healthy, 1 lost, 2 test
    bit m_err;

    clkmon_top #(.SYNC_STAGES(2), .IDLE_LIMIT(LIMIT)) dut_i (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .mon_clk    (mon_clk),
        .clr_req    (clr_req),
        .self_test  (self_test),
        .timing_err (timing_err)
    );

    always #10 ref_clk = ~ref_clk;   // 50 MHz

    // reference model, evaluated at each rising edge on pre-edge values
    always @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            sq = {1'b0};
            m_s1 = 0; m_prev = 0; m_stprev = 0;
            m_idle = 0; m_state = 0; m_err = 0;
        end else begin
            bit tog, stale, auto_c;
            tog    = (m_s1 != m_prev);
            stale  = (m_idle >= LIMIT);
            auto_c = m_stprev && !self_test;
            if (self_test)                      m_state = 2;
            else if (m_state == 0 && stale)     m_state = 1;
            else if (m_state == 1 && clr_req && !stale) m_state = 0;
            else if (m_state == 2)              m_state = (auto_c && !stale) ? 0 : 1;
            m_err = (m_state != 0);
            if (tog)                m_idle = 0;
            else if (m_idle < LIMIT) m_idle = m_idle + 1;
            m_prev = m_s1;
            sq.push_back(mon_clk);
            m_s1 = sq.pop_front();
            m_stprev = self_test;
        end
    end

    // monitored clock generator, moves at falling edges
    always @(negedge ref_clk) begin
        if (mon_run) begin
            mon_cnt++;
            if (mon_cnt >= mon_half) begin
                mon_cnt = 0;
                mon_clk = ~mon_clk;
            end
        end
    end

    // per-cycle comparison
    always @(negedge ref_clk) begin
        if (rst_n) begin
            checks++;
            if (timing_err !== m_err) begin
                errors++;
                $display("FAIL %s cycle %0d: timing_err=%0b expected %0b",
                         phase, cycles, timing_err, m_err);
            end
        end
    end

    // watchdog
    always @(posedge ref_clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic pcheck(input string tag, input logic exp);
        checks++;
        if (timing_err !== exp) begin
            errors++;
            $display("FAIL %s: timing_err=%0b expected %0b", tag, timing_err, exp);
        end
    endtask

    task automatic pulse_clr();
        clr_req = 1'b1;
        @(negedge ref_clk);
        clr_req = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        pcheck("R1", 1'b0);

        phase = "R2"; mon_half = 3; mon_run = 1;
        wait_cyc(60); pcheck("R2", 1'b0);
        mon_half = 7;
        wait_cyc(60); pcheck("R2", 1'b0);

        phase = "R3"; mon_run = 0;
        wait_cyc(LIMIT + 6); pcheck("R3", 1'b1);

        phase = "R4"; mon_half = 3; mon_run = 1;
        wait_cyc(20); pcheck("R4", 1'b1);

        phase = "R5"; pulse_clr(); pcheck("R5", 1'b0);
        wait_cyc(10); pcheck("R5", 1'b0);

        phase = "R6"; mon_run = 0;
        wait_cyc(LIMIT + 10);
        pulse_clr(); pcheck("R6", 1'b1);
        wait_cyc(3); pcheck("R6", 1'b1);
        mon_run = 1; wait_cyc(12);
        pulse_clr(); pcheck("R5", 1'b0);

        phase = "R7"; pulse_clr(); pcheck("R7", 1'b0);
        wait_cyc(5); pcheck("R7", 1'b0);

        phase = "R8"; self_test = 1'b1;
        wait_cyc(1); pcheck("R8", 1'b1);
        wait_cyc(15); pcheck("R8", 1'b1);
        phase = "R10"; pulse_clr(); pcheck("R10", 1'b1);
        wait_cyc(3);
        phase = "R9"; self_test = 1'b0;
        wait_cyc(1); pcheck("R9", 1'b0);
        wait_cyc(10); pcheck("R9", 1'b0);

        phase = "R9"; self_test = 1'b1; mon_run = 0;
        wait_cyc(LIMIT + 8); pcheck("R8", 1'b1);
        self_test = 1'b0;
        wait_cyc(1); pcheck("R9", 1'b1);
        wait_cyc(5); pcheck("R9", 1'b1);
        mon_run = 1; wait_cyc(12);
        pulse_clr(); pcheck("R5", 1'b0);
        wait_cyc(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule